// File: doc/BRIEF.md
# Prioritized Interrupt Context Switcher

This block sits beside a processor core that keeps its general registers in memory, in a workspace addressed by a workspace pointer. It decides whether a pending interrupt is taken. If so, it performs the whole context switch by itself through memory cycles, so the core never needs a stack. At each instruction boundary the core pulses a strobe. The block then looks at a hardware request and its 4-bit level, compares the level with the mask field of the current status word, and also looks at a software vector request.

A request that is taken selects a two-word vector. The first word is the new workspace pointer and the second is the new program counter. The block reads both words, then stores the interrupted workspace pointer, program counter and status into the last three registers of the new workspace. It finally presents the new PC, WP and ST together with a one-cycle acknowledge. A hardware entry also lowers the mask so that only more urgent levels can nest. All addresses are byte addresses and every access is one 16-bit word.

Top module: `icx_switcher`

## Requirements
- R1: After a synchronous active-low reset, mem_req, mem_we, ack and busy are 0 and new_pc, new_wp and new_st are all 0.
- R2: A hardware request is taken only when boundary and irq_req are both 1 at a clock edge and irq_level is less than or equal to the mask field cur_st[3:0]. Level 0 is the most urgent. A request that is not taken starts no memory cycle.
- R3: For a hardware entry at level L, the block first reads the new WP from byte address 4·L and then reads the new PC from byte address 4·L+2. Both are reads (mem_we = 0).
- R4: A software request (sw_req with index sw_num = n at a boundary) is taken regardless of the mask. It reads its vector from byte addresses 0x40+4·n and 0x40+4·n+2, and new_st equals the interrupted status unchanged.
- R5: After the two reads, the block writes three words in this order: old WP to new WP+26, old PC to new WP+28, old ST to new WP+30. The saved values are the ones present on cur_wp, cur_pc and cur_st at the accepting edge.
- R6: On a hardware entry at level L, new_st equals the old status with bits [3:0] replaced by L−1, or by 0 when L is 0. All other bits are unchanged.
- R7: ack is high for exactly one cycle, in the cycle after the third write completes. new_pc and new_wp hold the two vector words at that point and stay stable until the next accepted request.
- R8: When a hardware request that passes the mask and a software request meet at the same boundary, only the hardware entry is performed.
- R9: Requests with boundary low, and boundary strobes while busy is 1, start nothing.
- R10: A memory cycle completes only at an edge where mem_ready is 1. While mem_ready is 0, mem_req, mem_we, mem_addr and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Instruction boundary strobe; requests are sampled only when it is high |
| irq_req | input | 1 | Hardware interrupt request |
| irq_level | input | 4 | Level of the hardware request, 0 most urgent |
| sw_req | input | 1 | Software vector request |
| sw_num | input | 4 | Software vector index |
| cur_pc | input | 16 | Program counter of the running context |
| cur_wp | input | 16 | Workspace pointer of the running context |
| cur_st | input | 16 | Status word of the running context; bits [3:0] are the mask |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 for a write cycle, 0 for a read |
| mem_addr | output | 16 | Byte address of the word accessed |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current memory cycle at this edge |
| new_pc | output | 16 | Program counter of the entered context |
| new_wp | output | 16 | Workspace pointer of the entered context |
| new_st | output | 16 | Status word of the entered context |
| ack | output | 1 | One-cycle pulse when the switch is complete |
| busy | output | 1 | A context switch is in progress |

## Verification
The hardest situation to reach from the ports is a fresh boundary strobe, carrying a more urgent request, that arrives while a switch is still running. It has to be ignored without corrupting the saved context. The bench reaches it by raising boundary and a level-0 request in the middle of a sequence. It then checks that exactly five memory cycles occur and that none follows the acknowledge. Wait states are mixed in by toggling mem_ready on alternate cases of the full sweep over 16 masks and 16 levels. After the accepting edge the bench scrambles the current-context inputs, which shows that the saved words come from that edge.

// File: rtl/icx_pkg.sv
// Package: shared types for the interrupt context switcher.
// Assumes nothing beyond a single clock domain.
package icx_pkg;

    // Sequencer phases, in the order the memory cycles are issued
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RD_WP = 3'd1,
        S_RD_PC = 3'd2,
        S_WR13  = 3'd3,
        S_WR14  = 3'd4,
        S_WR15  = 3'd5,
        S_ACK   = 3'd6
    } icx_state_e;

endpackage

// File: rtl/icx_gate.sv
// Acceptance gate: decides at an instruction boundary whether a hardware
// or software request is taken. Hardware wins when both qualify.
// Assumes boundary is already suppressed by the caller while a switch runs.
module icx_gate #(
    parameter int LW = 4
) (
    input  logic          boundary,
    input  logic          irq_req,
    input  logic [LW-1:0] irq_level,
    input  logic [LW-1:0] mask,
    input  logic          sw_req,
    input  logic [LW-1:0] sw_num,
    output logic          take,
    output logic          take_hw,
    output logic [LW-1:0] take_idx
);

    logic hw_ok;
    logic sw_ok;

    // Qualify each request source and pick one
    always_comb begin
        hw_ok    = boundary && irq_req && (irq_level <= mask);
        sw_ok    = boundary && sw_req && !hw_ok;
        take     = hw_ok || sw_ok;
        take_hw  = hw_ok;
        take_idx = hw_ok ? irq_level : sw_num;
    end

endmodule

// File: rtl/icx_addr.sv
// Address generator: forms the byte address of each memory cycle from the
// current phase, the selected vector and the freshly loaded workspace.
// Assumes words are REG_BYTES wide and a vector is two consecutive words.
module icx_addr
    import icx_pkg::*;
#(
    parameter int           AW         = 16,
    parameter int           LW         = 4,
    parameter int           REG_BYTES  = 2,
    parameter int           SAVE_FIRST = 13,
    parameter logic [AW-1:0] SW_BASE   = 16'h0040
) (
    input  icx_state_e    state,
    input  logic          is_hw,
    input  logic [LW-1:0] idx,
    input  logic [AW-1:0] wp,
    output logic [AW-1:0] addr
);

    localparam int            VEC_SHIFT = $clog2(2 * REG_BYTES);
    localparam logic [AW-1:0] OFF0 = AW'(SAVE_FIRST * REG_BYTES);
    localparam logic [AW-1:0] OFF1 = AW'((SAVE_FIRST + 1) * REG_BYTES);
    localparam logic [AW-1:0] OFF2 = AW'((SAVE_FIRST + 2) * REG_BYTES);
    localparam logic [AW-1:0] STEP = AW'(REG_BYTES);

    logic [AW-1:0] vec_base;

    // Vector location: table base plus index times vector size
    always_comb begin
        vec_base = (is_hw ? '0 : SW_BASE) + (AW'(idx) << VEC_SHIFT);
    end

    // Per-phase address selection
    always_comb begin
        unique case (state)
            S_RD_WP: addr = vec_base;
            S_RD_PC: addr = vec_base + STEP;
            S_WR13:  addr = wp + OFF0;
            S_WR14:  addr = wp + OFF1;
            S_WR15:  addr = wp + OFF2;
            default: addr = '0;
        endcase
    end

endmodule

// File: rtl/icx_seq.sv
// Sequencer: snapshots the interrupted context on acceptance, runs two
// vector reads and three save writes with a ready handshake, then pulses
// ack. Assumes the mask field sits at MASK_LSB of the status word.
module icx_seq
    import icx_pkg::*;
#(
    parameter int DW       = 16,
    parameter int LW       = 4,
    parameter int MASK_LSB = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          take_hw,
    input  logic [LW-1:0] take_idx,
    input  logic [DW-1:0] cur_pc,
    input  logic [DW-1:0] cur_wp,
    input  logic [DW-1:0] cur_st,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output icx_state_e    state,
    output logic          lat_hw,
    output logic [LW-1:0] lat_idx,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] new_pc,
    output logic [DW-1:0] new_wp,
    output logic [DW-1:0] new_st,
    output logic          ack,
    output logic          busy
);

    logic [DW-1:0] old_pc;
    logic [DW-1:0] old_wp;
    logic [DW-1:0] old_st;
    logic [DW-1:0] st_masked;

    // Status word for a hardware entry: mask lowered one below the level
    always_comb begin
        st_masked = cur_st;
        st_masked[MASK_LSB +: LW] = (take_idx == '0) ? '0 : take_idx - LW'(1);
    end

    // Phase register, context snapshot and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            lat_hw  <= 1'b0;
            lat_idx <= '0;
            old_pc  <= '0;
            old_wp  <= '0;
            old_st  <= '0;
            new_pc  <= '0;
            new_wp  <= '0;
            new_st  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (take) begin
                    lat_hw  <= take_hw;
                    lat_idx <= take_idx;
                    old_pc  <= cur_pc;
                    old_wp  <= cur_wp;
                    old_st  <= cur_st;
                    new_st  <= take_hw ? st_masked : cur_st;
                    state   <= S_RD_WP;
                end
                S_RD_WP: if (mem_ready) begin
                    new_wp <= mem_rdata;
                    state  <= S_RD_PC;
                end
                S_RD_PC: if (mem_ready) begin
                    new_pc <= mem_rdata;
                    state  <= S_WR13;
                end
                S_WR13: if (mem_ready) state <= S_WR14;
                S_WR14: if (mem_ready) state <= S_WR15;
                S_WR15: if (mem_ready) state <= S_ACK;
                S_ACK:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory cycle controls and write data per phase
    always_comb begin
        mem_req   = (state == S_RD_WP) || (state == S_RD_PC) || (state == S_WR13)
                 || (state == S_WR14) || (state == S_WR15);
        mem_we    = (state == S_WR13) || (state == S_WR14) || (state == S_WR15);
        ack       = (state == S_ACK);
        busy      = (state != S_IDLE);
        unique case (state)
            S_WR13:  mem_wdata = old_wp;
            S_WR14:  mem_wdata = old_pc;
            S_WR15:  mem_wdata = old_st;
            default: mem_wdata = '0;
        endcase
    end

    // R7: acknowledge lasts one cycle and no memory cycle follows it at once
    p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack && !mem_req));

    // R6: a hardware entry never raises the mask; it drops it unless already 0
    p_mask_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && lat_hw) |-> ((new_st[MASK_LSB +: LW] < old_st[MASK_LSB +: LW])
                             || (old_st[MASK_LSB +: LW] == '0)));

    // R4: a software entry leaves the status word untouched
    p_sw_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !lat_hw) |-> (new_st == old_st));

endmodule

// File: rtl/icx_switcher.sv
// Top: prioritized interrupt context switcher. Gates requests at
// instruction boundaries, then drives a five-cycle memory sequence that
// loads a new workspace/PC pair and saves the old context into it.
// Assumes one word per memory cycle and byte addressing.
module icx_switcher
    import icx_pkg::*;
#(
    parameter int            DW         = 16,
    parameter int            AW         = 16,
    parameter int            LW         = 4,
    parameter int            MASK_LSB   = 0,
    parameter int            SAVE_FIRST = 13,
    parameter logic [AW-1:0] SW_BASE    = 16'h0040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          irq_req,
    input  logic [LW-1:0] irq_level,
    input  logic          sw_req,
    input  logic [LW-1:0] sw_num,
    input  logic [DW-1:0] cur_pc,
    input  logic [DW-1:0] cur_wp,
    input  logic [DW-1:0] cur_st,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic [DW-1:0] new_pc,
    output logic [DW-1:0] new_wp,
    output logic [DW-1:0] new_st,
    output logic          ack,
    output logic          busy
);

    localparam int REG_BYTES = DW / 8;

    icx_state_e    state;
    logic          gate_bnd;
    logic          take;
    logic          take_hw;
    logic [LW-1:0] take_idx;
    logic          lat_hw;
    logic [LW-1:0] lat_idx;

    // Boundary strobes are ignored while a switch is running
    always_comb gate_bnd = boundary && !busy;

    icx_gate #(.LW(LW)) u_gate (
        .boundary (gate_bnd),
        .irq_req  (irq_req),
        .irq_level(irq_level),
        .mask     (cur_st[MASK_LSB +: LW]),
        .sw_req   (sw_req),
        .sw_num   (sw_num),
        .take     (take),
        .take_hw  (take_hw),
        .take_idx (take_idx)
    );

    icx_seq #(.DW(DW), .LW(LW), .MASK_LSB(MASK_LSB)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_hw  (take_hw),
        .take_idx (take_idx),
        .cur_pc   (cur_pc),
        .cur_wp   (cur_wp),
        .cur_st   (cur_st),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .state    (state),
        .lat_hw   (lat_hw),
        .lat_idx  (lat_idx),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .new_pc   (new_pc),
        .new_wp   (new_wp),
        .new_st   (new_st),
        .ack      (ack),
        .busy     (busy)
    );

    icx_addr #(
        .AW(AW), .LW(LW), .REG_BYTES(REG_BYTES),
        .SAVE_FIRST(SAVE_FIRST), .SW_BASE(SW_BASE)
    ) u_addr (
        .state(state),
        .is_hw(lat_hw),
        .idx  (lat_idx),
        .wp   (AW'(new_wp)),
        .addr (mem_addr)
    );

    // R10: a stalled cycle keeps every control and data output steady
    p_hold_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
                                     && $stable(mem_addr) && $stable(mem_wdata)));

    // R2: no memory traffic outside a running switch
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R9: a busy switcher never restarts on a new strobe
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> busy);

endmodule

// File: tb/icx_switcher_test.sv
`timescale 1ns/1ps
module icx_switcher_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0, irq_req = 1'b0, sw_req = 1'b0;
    logic [3:0]  irq_level = '0, sw_num = '0;
    logic [15:0] cur_pc = '0, cur_wp = '0, cur_st = '0;
    logic        mem_req, mem_we, mem_ready, ack, busy;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, new_pc, new_wp, new_st;
    logic        stall_en = 1'b0;
    logic [31:0] cyc = '0;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    logic [15:0] t_addr [0:15];
    logic        t_we   [0:15];
    logic [15:0] t_data [0:15];
    int          t_n = 0;

    always #2.5 clk = ~clk;

    icx_switcher uut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq_req(irq_req),
        .irq_level(irq_level), .sw_req(sw_req), .sw_num(sw_num),
        .cur_pc(cur_pc), .cur_wp(cur_wp), .cur_st(cur_st),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .new_pc(new_pc), .new_wp(new_wp), .new_st(new_st), .ack(ack), .busy(busy)
    );

    function automatic logic [15:0] mem_fn(input logic [15:0] a);
        return {a[7:0] ^ 8'hC3, a[6:0], 1'b0};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;
    assign mem_ready = stall_en ? cyc[0] : 1'b1;
    assign mem_rdata = mem_fn(mem_addr);

    // Transaction log: one entry per completed memory cycle
    always @(negedge clk) begin
        if (mem_req && mem_ready && t_n < 16) begin
            t_addr[t_n] = mem_addr;
            t_we[t_n]   = mem_we;
            t_data[t_n] = mem_wdata;
            t_n = t_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One boundary with given requests; poke raises a strobe mid-sequence
    task automatic run_case(input bit hw, input bit sw, input logic [3:0] lvl,
                            input logic [3:0] num, input logic [15:0] st,
                            input logic [15:0] pc, input logic [15:0] wp,
                            input bit poke);
        bit          acc_hw, acc;
        logic [15:0] vec, nwp, npc, nst;
        bit          seen;
        acc_hw = hw && (lvl <= st[3:0]);
        acc    = acc_hw || sw;
        vec    = acc_hw ? 16'(lvl) * 16'd4 : 16'h0040 + 16'(num) * 16'd4;
        nwp    = mem_fn(vec);
        npc    = mem_fn(vec + 16'd2);
        nst    = acc_hw ? {st[15:4], (lvl == 0) ? 4'd0 : lvl - 4'd1} : st;
        @(negedge clk);
        t_n = 0;
        irq_req = hw; irq_level = lvl; sw_req = sw; sw_num = num;
        cur_st = st; cur_pc = pc; cur_wp = wp; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0; irq_req = 1'b0; sw_req = 1'b0;
        cur_pc = ~pc; cur_wp = ~wp; cur_st = ~st;
        if (!acc) begin
            for (int i = 0; i < 8; i++) begin
                chk("R2 no cycle when rejected", {31'd0, mem_req}, 32'd0);
                @(negedge clk);
            end
            chk("R2 log empty", t_n, 0);
        end else begin
            seen = 1'b0;
            for (int i = 0; i < 60 && !seen; i++) begin
                if (poke && i == 1) begin
                    boundary = 1'b1; irq_req = 1'b1; irq_level = 4'd0;
                    cur_st = 16'h000F;
                end
                if (poke && i == 2) begin
                    boundary = 1'b0; irq_req = 1'b0;
                end
                if (ack) seen = 1'b1;
                else @(negedge clk);
            end
            chk("R7 ack seen", {31'd0, seen}, 32'd1);
            chk("R9 R5 five cycles", t_n, 5);
            chk("R3 R4 WP addr", {16'd0, t_addr[0]}, {16'd0, vec});
            chk("R3 WP read", {31'd0, t_we[0]}, 32'd0);
            chk("R3 R4 PC addr", {16'd0, t_addr[1]}, {16'd0, vec + 16'd2});
            chk("R3 PC read", {31'd0, t_we[1]}, 32'd0);
            chk("R5 save WP addr", {15'd0, t_we[2], t_addr[2]}, {15'd0, 1'b1, nwp + 16'd26});
            chk("R5 save WP data", {16'd0, t_data[2]}, {16'd0, wp});
            chk("R5 save PC addr", {15'd0, t_we[3], t_addr[3]}, {15'd0, 1'b1, nwp + 16'd28});
            chk("R5 save PC data", {16'd0, t_data[3]}, {16'd0, pc});
            chk("R5 save ST addr", {15'd0, t_we[4], t_addr[4]}, {15'd0, 1'b1, nwp + 16'd30});
            chk("R5 save ST data", {16'd0, t_data[4]}, {16'd0, st});
            chk("R7 new_wp", {16'd0, new_wp}, {16'd0, nwp});
            chk("R7 new_pc", {16'd0, new_pc}, {16'd0, npc});
            chk(acc_hw ? "R6 new_st" : "R4 new_st", {16'd0, new_st}, {16'd0, nst});
            @(negedge clk);
            chk("R7 ack one cycle", {31'd0, ack}, 32'd0);
            for (int i = 0; i < 4; i++) begin
                chk("R9 idle after ack", {30'd0, mem_req, busy}, 32'd0);
                @(negedge clk);
            end
            chk("R7 results held", {new_pc, new_wp}, {npc, nwp});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset outputs", {28'd0, mem_req, mem_we, ack, busy}, 32'd0);
        chk("R1 reset pc/wp", {new_pc, new_wp}, 32'd0);
        chk("R1 reset st", {16'd0, new_st}, 32'd0);

        // R9: request without boundary does nothing
        @(negedge clk);
        irq_req = 1'b1; irq_level = 4'd0; cur_st = 16'h000F; sw_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9 no boundary no cycle", {31'd0, mem_req}, 32'd0);
        end
        irq_req = 1'b0; sw_req = 1'b0;

        // R2 R3 R6 R10: full mask x level sweep, stalls on odd levels
        for (int m = 0; m < 16; m++)
            for (int l = 0; l < 16; l++) begin
                stall_en = l[0];
                run_case(1'b1, 1'b0, 4'(l), 4'd0, {12'h5A3, 4'(m)},
                         16'(16'h1000 + m * 16 + l), 16'(16'h0800 + l * 32), 1'b0);
            end

        // R4: every software vector, mask irrelevant
        for (int n = 0; n < 16; n++) begin
            stall_en = n[1];
            run_case(1'b0, 1'b1, 4'd0, 4'(n), {12'hC3C, 4'(n ^ 5)},
                     16'(16'h2000 + n), 16'(16'h0400 + n * 32), 1'b0);
        end

        // R8: hardware beats software when it qualifies; software when it does not
        stall_en = 1'b0;
        run_case(1'b1, 1'b1, 4'd3, 4'd9, 16'h8007, 16'h3333, 16'h0600, 1'b0);
        run_case(1'b1, 1'b1, 4'd9, 4'd6, 16'h8004, 16'h4444, 16'h0620, 1'b0);

        // R9: strobe with urgent request while busy is ignored
        stall_en = 1'b1;
        run_case(1'b1, 1'b0, 4'd7, 4'd0, 16'h000A, 16'hBEEF, 16'h0700, 1'b1);
        stall_en = 1'b0;
        run_case(1'b0, 1'b1, 4'd0, 4'd2, 16'h0000, 16'hCAFE, 16'h0720, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule